// File: doc/BRIEF.md
# Dual-Channel Transmit Staging FIFO

This block is the transmit side of a small memory-mapped network controller. A host writes through a simple register-write port. It chooses one of two byte FIFOs, loads 32-bit words into that FIFO, programs a frame length for the channel, and then starts the channel. Once started, the channel's bytes leave through a byte-wide valid/ready stream, and the final byte carries a last flag. When the frame is complete, the channel's FIFO and its length register are emptied and a per-channel completion status bit is set. A single interrupt line combines the status bits with an enable mask.

Only one frame is on the output stream at any time. A start accepted while the other channel is draining is held pending. It goes out when the stream is free, so frames leave in the order their starts were accepted. The output follows the usual back-pressure rules. `out_valid` rises without waiting for `out_ready`. A byte moves on every clock edge where both are high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values.

Write addresses (4-bit): 0 = transmit control (bit 0 is the global transmit enable), 1 = channel select, 2 = data word, 3 = channel 0 length, 4 = channel 1 length, 5 = channel 0 start, 6 = channel 1 start, 7 = interrupt enable (bit n is channel n), 8 = interrupt status (write ones to clear). Every register resets to zero.

Top module: `tx_stage_top`

## Requirements
- R1: A channel-select write of 0 or 1 directs later data writes to that channel; any value of 2 or more selects channel 0.
- R2: A data write stores its four bytes in the selected FIFO starting with bits [7:0] and ending with bits [31:24], and they are sent in that order.
- R3: A data write is discarded whole when the selected FIFO has fewer than 4 free bytes (capacity DEPTH, default 64); the stored bytes are unchanged.
- R4: A length write whose 32-bit value exceeds DEPTH stores DEPTH.
- R5: A start write begins a frame only when its bit 0 is 1 and the global transmit enable is 1; otherwise it has no effect.
- R6: A started frame sends the lesser of the programmed length and the bytes held at the start; if that is zero the start has no effect.
- R7: When a channel's last byte is transferred, that channel's FIFO and length are cleared, and interrupt status bit n (n = channel) is set.
- R8: `irq` is high exactly when some status bit is set together with the same enable bit; writing a 1 to a status bit clears it.
- R9: Output bytes follow valid/ready: data and last hold while stalled, and `out_last` is high only on the frame's final byte.
- R10: A start on a channel that is pending or draining is ignored. A start on the idle channel while the other drains is queued, and its frame follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| out_data | output | 8 | Output frame byte |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Sink accepts the byte |
| irq | output | 1 | Combined interrupt |
| irq_status | output | 2 | Per-channel completion status |

## Verification
The bench sends frames with a word-sized length, an odd length shorter than the data held, and a full FIFO behind an extra data word and an over-range length. Together these separate the right byte order, truncation and overflow drop from the wrong ones. The over-range length is 129, so a design that kept only the low bits would send one byte instead of 64. Starts are also issued with the enable off, with bit 0 clear, on an empty FIFO and with a cleared length, and each of these must produce no output. Back-to-back starts on both channels, plus a repeated start during draining, check queuing order and that the repeat is ignored, under both steady and stalling `out_ready`.

// File: rtl/tx_stage_pkg.sv
package tx_stage_pkg;
  localparam int NCH = 2;
  localparam int CHW = 1;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_SEL   = 4'd1;
  localparam logic [3:0] A_DATA  = 4'd2;
  localparam logic [3:0] A_LEN0  = 4'd3;
  localparam logic [3:0] A_GO0   = 4'd5;
  localparam logic [3:0] A_IEN   = 4'd7;
  localparam logic [3:0] A_ISTAT = 4'd8;
endpackage

// File: rtl/tx_byte_fifo.sv
module tx_byte_fifo #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [31:0]   wdata,
  input  logic          pop,
  input  logic          clear,
  output logic [7:0]    head,
  output logic [CW-1:0] count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [CW:0]   free_b;
  logic          push_ok;

  assign free_b  = (CW+1)'(DEPTH) - {1'b0, cnt};
  assign push_ok = push && (free_b >= (CW+1)'(4));

  always_ff @(posedge clk) begin
    if (push_ok && !clear) begin
      for (int k = 0; k < 4; k++) mem[wptr + AW'(k)] <= wdata[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clear) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(4);
      if (pop)     rptr <= rptr + AW'(1);
      cnt <= cnt + (push_ok ? CW'(4) : CW'(0)) - CW'(pop);
    end
  end

  assign head  = mem[rptr];
  assign count = cnt;

  // R3: occupancy never passes capacity
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3: a write into a nearly full FIFO leaves it unchanged
  a_r3_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
    (push && free_b < 4 && !pop && !clear) |=> count == $past(count));
  // R9: bytes are only taken from a non-empty FIFO
  a_r9_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0);
endmodule

// File: rtl/tx_drain_ctrl.sv
module tx_drain_ctrl #(
  parameter int NCH = 2,
  parameter int CW  = 7,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          go,
  input  logic [NCH-1:0][CW-1:0]  go_len,
  input  logic                    xfer,
  output logic                    busy,
  output logic [CHW-1:0]          act,
  output logic                    last,
  output logic [NCH-1:0]          done
);
  logic [NCH-1:0]         pend;
  logic [NCH-1:0][CW-1:0] plen;
  logic [NCH-1:0]         accept;
  logic [CW-1:0]          remain;
  logic                   busy_q;
  logic [CHW-1:0]         act_q;
  logic                   found;
  logic [CHW-1:0]         pick;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      accept[c] = go[c] && !pend[c] && !(busy_q && act_q == CHW'(c)) && go_len[c] != '0;
      if (pend[c]) begin
        found = 1'b1;
        pick  = CHW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      plen   <= '0;
      remain <= '0;
      busy_q <= 1'b0;
      act_q  <= '0;
    end else begin
      if (busy_q) begin
        if (xfer) begin
          remain <= remain - CW'(1);
          if (remain == CW'(1)) busy_q <= 1'b0;
        end
      end else if (found) begin
        busy_q     <= 1'b1;
        act_q      <= pick;
        remain     <= plen[pick];
        pend[pick] <= 1'b0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (accept[c]) begin
          pend[c] <= 1'b1;
          plen[c] <= go_len[c];
        end
      end
    end
  end

  assign busy = busy_q;
  assign act  = act_q;
  assign last = busy_q && remain == CW'(1);

  always_comb begin
    for (int c = 0; c < NCH; c++)
      done[c] = busy_q && xfer && remain == CW'(1) && act_q == CHW'(c);
  end

  // R10: a stalled frame keeps its channel and its byte count
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer) |=> busy_q && $stable(act_q) && $stable(remain));
  // R6: a frame never begins with nothing to send
  a_r6_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> remain != '0);
endmodule

// File: rtl/tx_stage_top.sv
module tx_stage_top #(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [7:0]  out_data,
  output logic        out_valid,
  output logic        out_last,
  input  logic        out_ready,
  output logic        irq,
  output logic [1:0]  irq_status
);
  import tx_stage_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic                   tx_en;
  logic [CHW-1:0]         sel;
  logic [NCH-1:0]         ien, ista;
  logic [NCH-1:0][CW-1:0] len_q, cnt, slen;
  logic [NCH-1:0][7:0]    head;
  logic [NCH-1:0]         go, done;
  logic                   busy, last, xfer;
  logic [CHW-1:0]         act;

  assign xfer = busy && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0;
      sel   <= '0;
      ien   <= '0;
      ista  <= '0;
    end else begin
      if (wr_en && wr_addr == A_CTRL) tx_en <= wr_data[0];
      if (wr_en && wr_addr == A_SEL)
        sel <= (wr_data < 32'(NCH)) ? wr_data[CHW-1:0] : '0;
      if (wr_en && wr_addr == A_IEN) ien <= wr_data[NCH-1:0];
      ista <= (ista & ~((wr_en && wr_addr == A_ISTAT) ? wr_data[NCH-1:0] : '0)) | done;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) len_q[c] <= '0;
      else if (done[c]) len_q[c] <= '0;
      else if (wr_en && wr_addr == A_LEN0 + 4'(c))
        len_q[c] <= (wr_data > 32'(DEPTH)) ? CW'(DEPTH) : CW'(wr_data);
    end

    assign slen[c] = (len_q[c] < cnt[c]) ? len_q[c] : cnt[c];
    assign go[c]   = wr_en && wr_addr == A_GO0 + 4'(c) && wr_data[0] && tx_en;

    tx_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wr_en && wr_addr == A_DATA && sel == CHW'(c)),
      .wdata (wr_data),
      .pop   (xfer && act == CHW'(c)),
      .clear (done[c]),
      .head  (head[c]),
      .count (cnt[c])
    );

    // R7: completion sets the channel's status bit
    a_r7_status_set: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |=> ista[c]);
    // R7: completion empties the channel's FIFO
    a_r7_fifo_empty: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |=> cnt[c] == '0);
    // R8: a write-one clear without a new completion drops the bit
    a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_ISTAT && wr_data[c] && !done[c]) |=> !ista[c]);
  end

  tx_drain_ctrl #(.NCH(NCH), .CW(CW)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (go),
    .go_len (slen),
    .xfer   (xfer),
    .busy   (busy),
    .act    (act),
    .last   (last),
    .done   (done)
  );

  assign out_valid  = busy;
  assign out_data   = head[act];
  assign out_last   = last;
  assign irq        = |(ista & ien);
  assign irq_status = ista;

  // R8: no status, no interrupt
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ista == '0) |-> !irq);
  // R9: a stalled byte stays on the bus unchanged
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: tb/tx_stage_top_tb.sv
module tx_stage_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  out_data;
  logic        out_valid, out_last, irq;
  logic        out_ready = 1'b1;
  logic [1:0]  irq_status;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R2";
  bit    bp_on = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [8:0]  expq[$];
  bit          stall_seen = 1'b0;
  logic [8:0]  stall_val;

  always #4 clk = ~clk;

  tx_stage_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .out_ready(out_ready), .irq(irq), .irq_status(irq_status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_bytes(input logic [31:0] w, input int n, input bit fin);
    for (int k = 0; k < n; k++)
      expq.push_back({(fin && k == n - 1), w[8*k +: 8]});
  endtask

  task automatic settle();
    for (int i = 0; i < 2000 && expq.size() != 0; i++) @(negedge clk);
    repeat (8) @(negedge clk);
    check(expq.size() == 0, cur_req, expq.size(), 0);
  endtask

  // Monitor: compare every transferred byte with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = bp_on ? lfsr[0] : 1'b1;
      #1;
      if (rst_n && stall_seen) begin
        // R9: stalled byte must not change
        check(out_valid && {out_last, out_data} == stall_val, "R9",
              {out_last, out_data}, stall_val);
      end
      stall_seen = 1'b0;
      if (rst_n && out_valid && !out_ready) begin
        stall_seen = 1'b1;
        stall_val  = {out_last, out_data};
      end
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, cur_req, {out_last, out_data}, 0);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          check({out_last, out_data} == e, cur_req, {out_last, out_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R8, R9)
    check(!out_valid, "R9", out_valid, 0);
    check(!irq, "R8", irq, 0);
    check(irq_status == 2'b00, "R7", irq_status, 0);

    // R1 / R2: out-of-range select falls back to channel 0, LSB first
    cur_req = "R1";
    wr(4'd0, 32'd1);
    wr(4'd1, 32'd3);
    wr(4'd2, 32'h44332211);
    wr(4'd3, 32'd4);
    expect_bytes(32'h44332211, 4, 1'b1);
    wr(4'd5, 32'd1);
    settle();
    check(irq_status == 2'b01, "R7", irq_status, 1);
    check(!irq, "R8", irq, 0);

    // R8: enable mask and write-one-to-clear
    wr(4'd7, 32'd1);
    @(negedge clk);
    check(irq, "R8", irq, 1);
    wr(4'd8, 32'd2);
    check(irq && irq_status == 2'b01, "R8", irq_status, 1);
    wr(4'd8, 32'd1);
    check(!irq && irq_status == 2'b00, "R8", irq_status, 0);

    // R6 / R7: truncated frame on channel 1, then cleared state
    cur_req = "R6";
    wr(4'd1, 32'd1);
    wr(4'd2, 32'h04030201);
    wr(4'd2, 32'h08070605);
    wr(4'd4, 32'd5);
    expect_bytes(32'h04030201, 4, 1'b0);
    expect_bytes(32'h08070605, 1, 1'b1);
    wr(4'd6, 32'd1);
    settle();
    check(irq_status == 2'b10, "R7", irq_status, 2);
    cur_req = "R7";
    wr(4'd2, 32'hDDCCBBAA);
    wr(4'd6, 32'd1);           // length was cleared: no frame
    settle();
    wr(4'd4, 32'd4);
    expect_bytes(32'hDDCCBBAA, 4, 1'b1);   // leftover 06..08 must be gone
    wr(4'd6, 32'd1);
    settle();
    wr(4'd8, 32'd3);

    // R5: start gating
    cur_req = "R5";
    wr(4'd0, 32'd0);
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h5A5A00EE);
    wr(4'd3, 32'd4);
    wr(4'd5, 32'd1);
    settle();
    check(irq_status == 2'b00, "R5", irq_status, 0);
    wr(4'd0, 32'd1);
    wr(4'd5, 32'd2);
    settle();
    check(irq_status == 2'b00, "R5", irq_status, 0);
    expect_bytes(32'h5A5A00EE, 4, 1'b1);
    wr(4'd5, 32'd1);
    settle();
    check(irq_status == 2'b01, "R5", irq_status, 1);
    wr(4'd8, 32'd3);

    // R6: zero effective length does nothing
    cur_req = "R6";
    wr(4'd2, 32'h99887766);
    wr(4'd3, 32'd0);
    wr(4'd5, 32'd1);
    wr(4'd4, 32'd4);           // channel 1 is empty
    wr(4'd6, 32'd1);
    settle();
    check(irq_status == 2'b00, "R6", irq_status, 0);
    wr(4'd3, 32'd4);
    expect_bytes(32'h99887766, 4, 1'b1);
    wr(4'd5, 32'd1);
    settle();
    wr(4'd8, 32'd3);

    // R3 / R4: overfill channel 1, length 129 clamps to 64, with stalls
    cur_req = "R3";
    bp_on = 1'b1;
    wr(4'd1, 32'd1);
    for (int i = 0; i < 17; i++) begin
      logic [31:0] w;
      w = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)} ^ 32'h80808080;
      wr(4'd2, w);
      if (i < 16) expect_bytes(w, 4, i == 15);
    end
    wr(4'd4, 32'd129);         // R4
    wr(4'd6, 32'd1);
    settle();
    check(irq_status == 2'b10, "R4", irq_status, 2);
    bp_on = 1'b0;
    wr(4'd8, 32'd3);

    // R10: queued start and ignored repeat
    cur_req = "R10";
    wr(4'd1, 32'd0);
    wr(4'd2, 32'h13121110);
    wr(4'd2, 32'h17161514);
    wr(4'd3, 32'd8);
    wr(4'd1, 32'd1);
    wr(4'd2, 32'h23222120);
    wr(4'd4, 32'd4);
    expect_bytes(32'h23222120, 4, 1'b1);
    expect_bytes(32'h13121110, 4, 1'b0);
    expect_bytes(32'h17161514, 4, 1'b1);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'd1;
    @(negedge clk);
    wr_addr = 4'd5;
    @(negedge clk);
    wr_addr = 4'd6;             // channel 1 draining: ignored
    @(negedge clk);
    wr_en = 1'b0;
    settle();
    check(irq_status == 2'b11, "R10", irq_status, 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule